// File: doc/BRIEF.md
# Output Protection and Fault Supervisor

This block sits beside the control loop of a step-down power stage. It decides when the stage may switch and when it must stop. Every clock it takes sampled codes for output voltage, voltage setpoint, output current and controller temperature. It compares them against limits, and the voltage limits scale with the setpoint. From those results it drives a stage-enable, an open-drain pull-down on a fault line shared by several modules, and an open-drain pull-down on a power-good flag.

An overvoltage stops the stage until the enable request is dropped. Undervoltage, overcurrent and overtemperature instead start a timed hiccup: the stage stays off for a fixed retry period and then restarts. An overtemperature restart also waits for the temperature to fall past a lower threshold. When any other module pulls the shared line low, the stage stops and does not pull the line itself. It runs again once the line is released. Each comparison must hold for two consecutive samples before it acts. One-sample noise is therefore rejected, and a real fault still stops the stage two clocks after it appears.

Codes use 1 mV per LSB for voltage and setpoint. Current is compared against a rated-current code. Temperature is in °C plus an offset of 64. The retry period is `CLK_HZ/1000*RETRY_MS` clock cycles, which is 130 ms by default.

Top module: `prot_supervisor`

## Requirements
- R1: While reset is low, and right after it, stageEn=0, faultPull=0, pgPull=1 and faultFlags=0.
- R2: A high enReq with no fault sets stageEn on the next clock. A low enReq turns the stage off, releases the fault line and clears faultFlags at the next clock, and it clears a latched overvoltage.
- R3: Overvoltage trips when voutCode*100 >= setCode*130 and voutCode >= 1000. It latches: stageEn stays 0 and faultPull stays 1 until enReq goes low, even after the voltage returns to normal. One code below the threshold does not trip.
- R4: The overvoltage floor applies at low setpoints. With setCode=500, voutCode=999 does not trip, although it is above 130 %, and voutCode=1000 trips.
- R5: Undervoltage (voutCode*100 < setCode*75) starts a retry only while the stage runs and rampActive is 0. It is ignored while rampActive=1, and exactly 75 % does not trip.
- R6: Overcurrent (curCode*100 >= I_RATED*140) starts a retry. With I_RATED=2000, the code 2799 does not trip and 2800 trips.
- R7: Overtemperature (tempCode >= 184, i.e. 120 °C) starts a retry. The restart waits until the retry period has elapsed and tempCode <= 174 (110 °C) has held for two samples.
- R8: During a retry, stageEn=0 and faultPull=1 for exactly RETRY_CYC clock cycles counted from the tripping edge. After that, stageEn returns to 1 and faultPull to 0.
- R9: A condition seen on two consecutive samples turns the stage off at the second clock edge, within 6 µs. A condition seen on a single sample has no effect.
- R10: pgPull goes to 0 after two consecutive samples with setCode*90 <= voutCode*100 <= setCode*110 (both limits inclusive), while the stage runs and rampActive=0. It returns to 1 after two consecutive samples outside that window, and at once when rampActive is high or the stage stops.
- R11: The fault line held low by another device for two samples (faultLineIn=0 while faultPull=0) sets stageEn=0 without asserting faultPull or changing faultFlags. The stage restarts one clock after the line is released.
- R12: faultFlags is one-hot and records only the first fault after enable: bit3 overvoltage, bit2 overtemperature, bit1 overcurrent, bit0 undervoltage. Later faults do not overwrite it. When faults trip together, the priority is overvoltage > overtemperature > overcurrent > undervoltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enReq | input | 1 | Enable request for the stage |
| rampActive | input | 1 | Output is ramping; masks undervoltage and power-good |
| voutCode | input | V_W | Sampled output voltage, 1 mV/LSB |
| setCode | input | V_W | Voltage setpoint, 1 mV/LSB |
| curCode | input | I_W | Sampled output current code |
| tempCode | input | T_W | Controller temperature, °C + T_OFS |
| faultLineIn | input | 1 | Sensed level of the shared fault line (0 = fault) |
| stageEn | output | 1 | Power stage allowed to switch |
| faultPull | output | 1 | Pull the shared fault line low |
| pgPull | output | 1 | Pull the power-good flag low |
| faultFlags | output | 4 | First-fault record, one-hot |

## Verification
The assertions assume that enReq, rampActive and every code change only once per clock and stay put around the edge. They also assume that faultLineIn is the wired-AND of this block's own pull and the outside pulls, so the block sees its own pull reflected on the line. The bench drives all inputs on the falling edge. It builds the fault line from the block's faultPull and a separate external pull. It holds each code pattern for whole cycles, which keeps every sample well defined for both the filters and the checker.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RUN   = 3'd1,
    ST_RETRY = 3'd2,
    ST_LATCH = 3'd3,
    ST_EXT   = 3'd4
  } supState_e;

  // filtered comparison results, datapath -> control
  typedef struct packed {
    logic ovTrip;
    logic otTrip;
    logic ocTrip;
    logic uvTrip;
    logic extTrip;
    logic otCool;
    logic winIn;
    logic winOut;
    logic retryDone;
  } cmpFlags_t;

  // strobes, control -> datapath
  typedef struct packed {
    logic retryClear;
    logic retryRun;
  } ctlStrobe_t;

  localparam int NUM_CMP = 8;
  localparam int FLAG_UV = 0;
  localparam int FLAG_OC = 1;
  localparam int FLAG_OT = 2;
  localparam int FLAG_OV = 3;
endpackage

// File: rtl/prot_datapath.sv
module prot_datapath
  import prot_pkg::*;
#(
  parameter int V_W       = 14,
  parameter int I_W       = 12,
  parameter int T_W       = 8,
  parameter int OV_PCT    = 130,
  parameter int UV_PCT    = 75,
  parameter int OC_PCT    = 140,
  parameter int PG_LO_PCT = 90,
  parameter int PG_HI_PCT = 110,
  parameter int OV_FLOOR  = 1000,
  parameter int I_RATED   = 2000,
  parameter int T_TRIP    = 184,
  parameter int T_CLEAR   = 174,
  parameter int RETRY_CYC = 6500000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [V_W-1:0]   voutCode,
  input  logic [V_W-1:0]   setCode,
  input  logic [I_W-1:0]   curCode,
  input  logic [T_W-1:0]   tempCode,
  input  logic             faultLineIn,
  input  logic             faultPullNow,
  input  ctlStrobe_t       strobe,
  output cmpFlags_t        flags
);
  localparam int VP_W  = V_W + 8;
  localparam int IP_W  = I_W + 8;
  localparam int CNT_W = $clog2(RETRY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RETRY_CYC - 1);

  localparam int IX_OV   = 0;
  localparam int IX_OT   = 1;
  localparam int IX_OC   = 2;
  localparam int IX_UV   = 3;
  localparam int IX_EXT  = 4;
  localparam int IX_COOL = 5;
  localparam int IX_IN   = 6;
  localparam int IX_OUT  = 7;

  logic [VP_W-1:0] vScaled, ovLimit, uvLimit, winLo, winHi;
  logic [IP_W-1:0] iScaled;
  logic            inWin;
  logic [NUM_CMP-1:0] rawCmp, prevCmp, fltCmp;
  logic [CNT_W-1:0]   retryCnt;

  always_comb begin
    vScaled = {8'd0, voutCode} * VP_W'(100);
    ovLimit = {8'd0, setCode}  * VP_W'(OV_PCT);
    uvLimit = {8'd0, setCode}  * VP_W'(UV_PCT);
    winLo   = {8'd0, setCode}  * VP_W'(PG_LO_PCT);
    winHi   = {8'd0, setCode}  * VP_W'(PG_HI_PCT);
    iScaled = {8'd0, curCode}  * IP_W'(100);
    inWin   = (vScaled >= winLo) && (vScaled <= winHi);

    rawCmp[IX_OV]   = (vScaled >= ovLimit) && (voutCode >= V_W'(OV_FLOOR));
    rawCmp[IX_OT]   = tempCode >= T_W'(T_TRIP);
    rawCmp[IX_OC]   = iScaled >= IP_W'(I_RATED * OC_PCT);
    rawCmp[IX_UV]   = vScaled < uvLimit;
    rawCmp[IX_EXT]  = !faultLineIn && !faultPullNow;
    rawCmp[IX_COOL] = tempCode <= T_W'(T_CLEAR);
    rawCmp[IX_IN]   = inWin;
    rawCmp[IX_OUT]  = !inWin;
  end

  // two-sample agreement filter on every comparison
  for (genvar g = 0; g < NUM_CMP; g++) begin : gen_filter
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prevCmp[g] <= 1'b0;
      else       prevCmp[g] <= rawCmp[g];
    end
    assign fltCmp[g] = rawCmp[g] & prevCmp[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 retryCnt <= '0;
    else if (strobe.retryClear) retryCnt <= '0;
    else if (strobe.retryRun && retryCnt != CNT_LAST) retryCnt <= retryCnt + 1'b1;
  end

  always_comb begin
    flags.ovTrip    = fltCmp[IX_OV];
    flags.otTrip    = fltCmp[IX_OT];
    flags.ocTrip    = fltCmp[IX_OC];
    flags.uvTrip    = fltCmp[IX_UV];
    flags.extTrip   = fltCmp[IX_EXT];
    flags.otCool    = fltCmp[IX_COOL];
    flags.winIn     = fltCmp[IX_IN];
    flags.winOut    = fltCmp[IX_OUT];
    flags.retryDone = (retryCnt == CNT_LAST);
  end
endmodule

// File: rtl/prot_ctrl.sv
module prot_ctrl
  import prot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enReq,
  input  logic       rampActive,
  input  cmpFlags_t  flags,
  output ctlStrobe_t strobe,
  output logic       stageEn,
  output logic       faultPull,
  output logic       pgPull,
  output logic [3:0] faultFlags
);
  supState_e  state, nextState;
  logic [3:0] tripMask;
  logic       otHot;
  logic       pgGood;

  always_comb begin
    nextState = state;
    tripMask  = '0;
    if (!enReq) begin
      nextState = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: nextState = ST_RUN;
        ST_RUN: begin
          if (flags.ovTrip) begin
            nextState = ST_LATCH;
            tripMask[FLAG_OV] = 1'b1;
          end else if (flags.otTrip) begin
            nextState = ST_RETRY;
            tripMask[FLAG_OT] = 1'b1;
          end else if (flags.ocTrip) begin
            nextState = ST_RETRY;
            tripMask[FLAG_OC] = 1'b1;
          end else if (flags.uvTrip && !rampActive) begin
            nextState = ST_RETRY;
            tripMask[FLAG_UV] = 1'b1;
          end else if (flags.extTrip) begin
            nextState = ST_EXT;
          end
        end
        ST_RETRY: if (flags.retryDone && !otHot) nextState = ST_RUN;
        ST_LATCH: nextState = ST_LATCH;
        ST_EXT:   if (!flags.extTrip) nextState = ST_RUN;
        default:  nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_OFF;
      otHot      <= 1'b0;
      faultFlags <= '0;
      pgGood     <= 1'b0;
    end else begin
      state <= nextState;

      if (!enReq)                 otHot <= 1'b0;
      else if (tripMask[FLAG_OT]) otHot <= 1'b1;
      else if (flags.otCool)      otHot <= 1'b0;

      if (!enReq)                 faultFlags <= '0;
      else if (faultFlags == '0)  faultFlags <= tripMask;

      if (nextState != ST_RUN || rampActive) pgGood <= 1'b0;
      else if (flags.winIn)                  pgGood <= 1'b1;
      else if (flags.winOut)                 pgGood <= 1'b0;
    end
  end

  always_comb begin
    strobe.retryClear = (state != ST_RETRY);
    strobe.retryRun   = (state == ST_RETRY);
    stageEn   = (state == ST_RUN);
    faultPull = (state == ST_RETRY) || (state == ST_LATCH);
    pgPull    = !pgGood;
  end
endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor
  import prot_pkg::*;
#(
  parameter int CLK_HZ   = 50000000,
  parameter int RETRY_MS = 130,
  parameter int V_W      = 14,
  parameter int I_W      = 12,
  parameter int T_W      = 8,
  parameter int OV_FLOOR = 1000,
  parameter int I_RATED  = 2000,
  parameter int T_OFS    = 64
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           enReq,
  input  logic           rampActive,
  input  logic [V_W-1:0] voutCode,
  input  logic [V_W-1:0] setCode,
  input  logic [I_W-1:0] curCode,
  input  logic [T_W-1:0] tempCode,
  input  logic           faultLineIn,
  output logic           stageEn,
  output logic           faultPull,
  output logic           pgPull,
  output logic [3:0]     faultFlags
);
  localparam int RETRY_CYC = (CLK_HZ / 1000) * RETRY_MS;
  localparam int T_TRIP    = 120 + T_OFS;
  localparam int T_CLEAR   = 110 + T_OFS;

  cmpFlags_t  cmpFlags;
  ctlStrobe_t ctlStrobe;

  prot_datapath #(
    .V_W(V_W), .I_W(I_W), .T_W(T_W),
    .OV_PCT(130), .UV_PCT(75), .OC_PCT(140),
    .PG_LO_PCT(90), .PG_HI_PCT(110),
    .OV_FLOOR(OV_FLOOR), .I_RATED(I_RATED),
    .T_TRIP(T_TRIP), .T_CLEAR(T_CLEAR),
    .RETRY_CYC(RETRY_CYC)
  ) u_datapath (
    .clk(clk), .rstN(rstN),
    .voutCode(voutCode), .setCode(setCode),
    .curCode(curCode), .tempCode(tempCode),
    .faultLineIn(faultLineIn), .faultPullNow(faultPull),
    .strobe(ctlStrobe), .flags(cmpFlags)
  );

  prot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .enReq(enReq), .rampActive(rampActive),
    .flags(cmpFlags), .strobe(ctlStrobe),
    .stageEn(stageEn), .faultPull(faultPull),
    .pgPull(pgPull), .faultFlags(faultFlags)
  );
endmodule

// File: rtl/prot_supervisor_chk.sv
module prot_supervisor_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enReq,
  input logic       rampActive,
  input logic       stageEn,
  input logic       faultPull,
  input logic       pgPull,
  input logic [3:0] faultFlags
);
  // R8: own fault line pull only while the stage is held off
  assert_pull_stage_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    faultPull |-> !stageEn);

  // R10: power good is only released while the stage runs
  assert_pg_needs_stage_R10: assert property (@(posedge clk) disable iff (!rstN)
    !pgPull |-> stageEn);

  // R10: a ramp forces the flag low on the next clock
  assert_pg_ramp_R10: assert property (@(posedge clk) disable iff (!rstN)
    rampActive |=> pgPull);

  // R12: first-fault record is one-hot or empty
  assert_flags_onehot_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(faultFlags));

  // R12: a recorded fault is never overwritten while enabled
  assert_flags_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (enReq && faultFlags != 4'b0000) |=> $stable(faultFlags));

  // R2: dropping the request stops the stage and clears the record
  assert_disable_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    !enReq |=> (!stageEn && !faultPull && faultFlags == 4'b0000));

  // R3: an overvoltage record keeps the stage off while enabled
  assert_ov_latched_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enReq && faultFlags[3]) |=> !stageEn);
endmodule

bind prot_supervisor prot_supervisor_chk u_chk (
  .clk(clk), .rstN(rstN), .enReq(enReq), .rampActive(rampActive),
  .stageEn(stageEn), .faultPull(faultPull), .pgPull(pgPull),
  .faultFlags(faultFlags)
);

// File: tb/tb_prot_supervisor.sv
module tb_prot_supervisor;
  localparam int CLK_HZ = 100000;
  localparam int RET    = (CLK_HZ / 1000) * 130;
  localparam int RATED  = 2000;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic enReq = 1'b0, rampActive = 1'b0, extPull = 1'b0;
  logic [13:0] voutCode = '0, setCode = 14'd1200;
  logic [11:0] curCode = 12'd1000;
  logic [7:0]  tempCode = 8'd104;
  logic stageEn, faultPull, pgPull;
  logic [3:0] faultFlags;
  wire faultLineIn = ~(faultPull | extPull);

  int tests = 0, fails = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  prot_supervisor #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rstN(rstN), .enReq(enReq), .rampActive(rampActive),
    .voutCode(voutCode), .setCode(setCode), .curCode(curCode),
    .tempCode(tempCode), .faultLineIn(faultLineIn),
    .stageEn(stageEn), .faultPull(faultPull), .pgPull(pgPull),
    .faultFlags(faultFlags)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural reference: 0 off, 1 run, 2 retry, 3 latched, 4 external hold
  int mState = 0, mCnt = 0, mFlags = 0;
  bit mOtHot = 0, mPg = 0;
  bit pOv, pOt, pOc, pUv, pExt, pCool, pIn, pOut;

  always @(posedge clk) begin : model
    int v, s, c, t, nxt, trip;
    bit rOv, rOt, rOc, rUv, rExt, rCool, rIn, rOut, mPull, done;
    if (!rstN) begin
      mState = 0; mCnt = 0; mFlags = 0; mOtHot = 0; mPg = 0;
      {pOv, pOt, pOc, pUv, pExt, pCool, pIn, pOut} = '0;
    end else begin
      v = voutCode; s = setCode; c = curCode; t = tempCode;
      mPull = (mState == 2) || (mState == 3);
      rOv = (v * 100 >= s * 130) && (v >= 1000);
      rOt = t >= 184;
      rOc = c * 100 >= RATED * 140;
      rUv = v * 100 < s * 75;
      rExt = extPull && !mPull;
      rCool = t <= 174;
      rIn = (v * 100 >= s * 90) && (v * 100 <= s * 110);
      rOut = !rIn;
      done = (mCnt == RET - 1);
      nxt = mState; trip = 0;
      if (!enReq) nxt = 0;
      else if (mState == 0) nxt = 1;
      else if (mState == 1) begin
        if (rOv && pOv) begin nxt = 3; trip = 8; end
        else if (rOt && pOt) begin nxt = 2; trip = 4; end
        else if (rOc && pOc) begin nxt = 2; trip = 2; end
        else if (rUv && pUv && !rampActive) begin nxt = 2; trip = 1; end
        else if (rExt && pExt) nxt = 4;
      end else if (mState == 2) begin
        if (done && !mOtHot) nxt = 1;
      end else if (mState == 4) begin
        if (!(rExt && pExt)) nxt = 1;
      end
      if (mState != 2) mCnt = 0;
      else if (!done) mCnt++;
      if (!enReq) mOtHot = 0;
      else if (trip == 4) mOtHot = 1;
      else if (rCool && pCool) mOtHot = 0;
      if (!enReq) mFlags = 0;
      else if (mFlags == 0) mFlags = trip;
      if (nxt != 1 || rampActive) mPg = 0;
      else if (rIn && pIn) mPg = 1;
      else if (rOut && pOut) mPg = 0;
      mState = nxt;
      {pOv, pOt, pOc, pUv, pExt, pCool, pIn, pOut} = {rOv, rOt, rOc, rUv, rExt, rCool, rIn, rOut};
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk(curReq, "model stageEn", stageEn, (mState == 1) ? 1 : 0);
      chk(curReq, "model faultPull", faultPull, (mState == 2 || mState == 3) ? 1 : 0);
      chk(curReq, "model pgPull", pgPull, mPg ? 0 : 1);
      chk(curReq, "model faultFlags", faultFlags, mFlags);
    end
  end

  task automatic reenable();
    enReq = 1'b0; tick(2); enReq = 1'b1; tick(3);
  endtask

  task automatic run_all();
    #5 rstN = 1'b0;
    tick(3);
    chk("R1", "stageEn in reset", stageEn, 0);
    chk("R1", "faultPull in reset", faultPull, 0);
    chk("R1", "pgPull in reset", pgPull, 1);
    chk("R1", "faultFlags in reset", faultFlags, 0);
    rstN = 1'b1; tick(2);
    chk("R1", "stageEn after reset", stageEn, 0);

    curReq = "R2"; enReq = 1'b1; rampActive = 1'b1; tick(1);
    chk("R2", "stageEn on enable", stageEn, 1);
    chk("R10", "pg held while ramping", pgPull, 1);
    tick(4);

    curReq = "R10"; voutCode = 14'd1200; rampActive = 1'b0; tick(1);
    chk("R10", "pg after one sample", pgPull, 1);
    tick(1);
    chk("R10", "pg after two samples", pgPull, 0);

    curReq = "R9"; voutCode = 14'd2000; tick(1); voutCode = 14'd1200; tick(5);
    chk("R9", "glitch ignored stageEn", stageEn, 1);
    chk("R9", "glitch ignored flags", faultFlags, 0);
    chk("R9", "glitch ignored pg", pgPull, 0);

    curReq = "R10";
    voutCode = 14'd1320; tick(3); chk("R10", "pg at 110%", pgPull, 0);
    voutCode = 14'd1080; tick(3); chk("R10", "pg at 90%", pgPull, 0);
    voutCode = 14'd1321; tick(1); voutCode = 14'd1200; tick(3);
    chk("R10", "single out sample", pgPull, 0);
    voutCode = 14'd1079; tick(2); chk("R10", "pg below window", pgPull, 1);
    voutCode = 14'd1200; tick(3);

    curReq = "R3";
    voutCode = 14'd1559; tick(5); chk("R3", "below ov", stageEn, 1);
    voutCode = 14'd1560; tick(1); chk("R9", "one ov sample", stageEn, 1);
    tick(1);
    chk("R9", "ov trip at second edge", stageEn, 0);
    chk("R3", "ov pulls line", faultPull, 1);
    chk("R3", "ov flag", faultFlags, 8);
    voutCode = 14'd1200; tick(50);
    chk("R3", "ov latched stage", stageEn, 0);
    chk("R3", "ov latched pull", faultPull, 1);
    curReq = "R2"; enReq = 1'b0; tick(1);
    chk("R2", "disable stage", stageEn, 0);
    chk("R2", "disable flags", faultFlags, 0);
    chk("R2", "disable pull", faultPull, 0);
    enReq = 1'b1; tick(1);
    chk("R2", "re-enable", stageEn, 1);

    curReq = "R4"; enReq = 1'b0; setCode = 14'd500; voutCode = 14'd500; tick(2);
    enReq = 1'b1; tick(3);
    voutCode = 14'd999; tick(10);
    chk("R4", "below floor", stageEn, 1);
    voutCode = 14'd1000; tick(2);
    chk("R4", "at floor", stageEn, 0);
    chk("R4", "floor flag", faultFlags, 8);
    enReq = 1'b0; setCode = 14'd1200; voutCode = 14'd1200; tick(2);
    enReq = 1'b1; tick(3);

    curReq = "R6";
    curCode = 12'd2799; tick(5); chk("R6", "below oc", stageEn, 1);
    curCode = 12'd2800; tick(2);
    chk("R6", "oc trip", stageEn, 0);
    chk("R6", "oc flag", faultFlags, 2);
    chk("R6", "oc pull", faultPull, 1);
    curCode = 12'd1000;
    curReq = "R8"; tick(RET - 1);
    chk("R8", "still off at end", stageEn, 0);
    chk("R8", "still pulling", faultPull, 1);
    tick(1);
    chk("R8", "restart", stageEn, 1);
    chk("R8", "release line", faultPull, 0);
    chk("R12", "flag kept", faultFlags, 2);

    curReq = "R5"; rampActive = 1'b1; voutCode = 14'd800; tick(10);
    chk("R5", "uv ignored in ramp", stageEn, 1);
    voutCode = 14'd900; rampActive = 1'b0; tick(5);
    chk("R5", "uv at 75%", stageEn, 1);
    voutCode = 14'd899; tick(2);
    chk("R5", "uv trip", stageEn, 0);
    chk("R12", "first flag kept", faultFlags, 2);
    voutCode = 14'd1200; tick(RET);
    chk("R5", "uv restart", stageEn, 1);

    curReq = "R7"; reenable();
    tempCode = 8'd183; tick(5); chk("R7", "below ot", stageEn, 1);
    curReq = "R12"; curCode = 12'd2800; tempCode = 8'd184; tick(2);
    chk("R12", "ot over oc", faultFlags, 4);
    chk("R7", "ot trip", stageEn, 0);
    curReq = "R7"; curCode = 12'd1000; tick(RET + 20);
    chk("R7", "hot holds off", stageEn, 0);
    tempCode = 8'd180; tick(10);
    chk("R7", "between thresholds", stageEn, 0);
    tempCode = 8'd174; tick(4);
    chk("R7", "cool restart", stageEn, 1);
    tempCode = 8'd104; tick(3);

    curReq = "R11"; extPull = 1'b1; tick(1);
    chk("R11", "one ext sample", stageEn, 1);
    tick(1);
    chk("R11", "ext stop", stageEn, 0);
    chk("R11", "no own pull", faultPull, 0);
    chk("R11", "flags unchanged", faultFlags, 4);
    tick(30); extPull = 1'b0; tick(1);
    chk("R11", "ext release", stageEn, 1);

    curReq = "R12"; reenable();
    voutCode = 14'd1600; curCode = 12'd2800; tempCode = 8'd184; tick(2);
    chk("R12", "ov priority", faultFlags, 8);
    enReq = 1'b0; voutCode = 14'd1200; curCode = 12'd1000; tempCode = 8'd104; tick(2);
    chk("R12", "cleared", faultFlags, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog expired");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule